// File: doc/BRIEF.md
# Two-Wire Slave with Shadowed DAC Set-Points

This block is a two-wire (I2C) slave. It holds the set-points of two DACs: a 10-bit one and an 8-bit one. Each set-point has a live (volatile) register that drives the DAC and a shadow (nonvolatile) copy. The shadow copy can be reached only through the live register. Reading a shadow word copies it into the live register first. Writing a shadow word loads the live register, and the Stop that closes the transaction then saves the value into the shadow. The save keeps the slave busy for a set time. During that time the slave does not acknowledge its own address.

The same slave also gives byte access to an external 256-byte lookup memory, which answers to a second device-type code. The memory is written through a one-cycle write strobe. It is read through a one-cycle read strobe with combinational data return. One address pointer, shared by both targets, is loaded by the word-address byte. It steps after each memory byte and wraps from 255 to 0.

SCL and SDA are sampled on the system clock. The slave pulls SDA low through `sda_oe`. Static configuration inputs set the register access rights, the memory lock, the memory device-type code, address-pin matching and the power-up value of each live register.

Top module: `i2c_dac_shadow_slave`

## Requirements
- R1: Device-type code 1001 (address bits 7:4 of the first byte) selects the DAC registers. The code 1010, or 1110 when `cfg_mem_alt` = 1, selects the memory. Any other code gets no acknowledge.
- R2: With `cfg_pin_match` = 1, address bits 3:1 must equal `pin_addr`, or the address gets no acknowledge. With `cfg_pin_match` = 0, those bits are ignored.
- R3: Bit 0 of the first byte is R/W, with 1 meaning read. An accepted address byte and every written byte are acknowledged by asserting `sda_oe` in the ninth SCL clock. `sda_oe` is 0 while the bus is idle and after a Stop.
- R4: Word 0 is the live 10-bit register. Its first data byte carries value bits 9:8 in its bits 1:0, and its second byte carries bits 7:0. `dac10` changes only when the second byte completes. Word 4 is the live 8-bit register, and `dac8` takes the byte when it completes.
- R5: Reading word 0 or word 4 returns the live value in the same byte layout and leaves `dac10`, `dac8` and the shadow copies unchanged.
- R6: Reading word 2 (10-bit shadow) or word 6 (8-bit shadow) first copies the shadow into the live register, so the DAC output changes, and then returns that value.
- R7: Writing word 2 or word 6 loads the live register as R4 does. The Stop that ends the transaction copies it into the shadow and raises `nv_busy` for `NV_BUSY_CYCLES` clock cycles.
- R8: `cfg_access` bit 1 allows register writes and bit 0 allows register reads: 00 locked, 01 read only, 10 write only, 11 both. An address byte whose direction is not allowed gets no acknowledge, and the bytes that follow have no effect.
- R9: Each memory data byte written makes one `mem_we` pulse at the current pointer and then steps the pointer. `cfg_mem_lock` = 1 makes the memory address unacknowledged.
- R10: Memory reads step the pointer after each byte is loaded and wrap from 255 to 0. A master ACK requests the next byte; a master NACK ends the transfer. A later current-address read continues from the pointer.
- R11: While `nv_busy` is 1, the slave does not acknowledge any address byte.
- R12: On reset, the shadows take `NV10_INIT` and `NV8_INIT`. Each live register loads its shadow when its init bit (`cfg_init10`, `cfg_init8`) is 1, and zero otherwise.
- R13: A random read is a write of the word address, then a repeated Start with R/W = 1. It returns the data at that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_addr | input | 3 | Strapped address pins |
| cfg_access | input | 2 | Register write/read permission bits |
| cfg_mem_lock | input | 1 | Blocks memory access |
| cfg_mem_alt | input | 1 | Selects the alternate memory device-type code |
| cfg_pin_match | input | 1 | Requires address bits 3:1 to match the pins |
| cfg_init10 | input | 1 | 10-bit live register loads its shadow on reset |
| cfg_init8 | input | 1 | 8-bit live register loads its shadow on reset |
| dac10 | output | 10 | Live 10-bit set-point |
| dac8 | output | 8 | Live 8-bit set-point |
| mem_addr | output | 8 | Memory address (pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_re | output | 1 | One-cycle memory read strobe |
| mem_rdata | input | 8 | Memory read data, combinational from `mem_addr` |
| nv_busy | output | 1 | Shadow save in progress |

## Verification
Bus events reach the logic through a two-stage synchroniser and an edge register, so every result follows the SCL edge that causes it by three to four clock cycles. Register updates, the acknowledge drive and read data appear after the SCL fall that opens the slot. `nv_busy` rises about three cycles after SDA rises for the Stop. The bench holds each SCL phase for eight clock cycles and samples SDA, the DAC outputs and `nv_busy` only at the end of a phase, after those latencies have passed. Read bytes go into a scoreboard queue that a monitor compares against the values the driver predicted.

// File: rtl/i2c_dac_shadow_slave.sv
module i2c_dac_shadow_slave #(
  parameter int         NV_BUSY_CYCLES = 2000,
  parameter logic [9:0] NV10_INIT      = 10'h155,
  parameter logic [7:0] NV8_INIT       = 8'h80,
  parameter logic [3:0] DAC_TYPE       = 4'b1001,
  parameter logic [3:0] MEM_TYPE       = 4'b1010,
  parameter logic [3:0] MEM_TYPE_ALT   = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] pin_addr,
  input  logic [1:0] cfg_access,
  input  logic       cfg_mem_lock,
  input  logic       cfg_mem_alt,
  input  logic       cfg_pin_match,
  input  logic       cfg_init10,
  input  logic       cfg_init8,
  output logic [9:0] dac10,
  output logic [7:0] dac8,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  output logic       mem_re,
  input  logic [7:0] mem_rdata,
  output logic       nv_busy
);
  localparam int BW = $clog2(NV_BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WORD, S_WR, S_RD} st_t;

  st_t        st;
  logic [2:0] scl_r, sda_r;
  logic [3:0] bitcnt;
  logic       skip, rw, tgt_dac, mack, hib, pend10, pend8;
  logic [7:0] shreg, tx, ptr, nv8, rd_dac, rd_byte;
  logic [1:0] hi_tmp;
  logic [9:0] nv10;
  logic [BW-1:0] busy_cnt;

  wire scl_s = scl_r[1], scl_p = scl_r[2];
  wire sda_s = sda_r[1], sda_p = sda_r[2];
  wire start_ev = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise = scl_s & ~scl_p;
  wire fall = ~scl_s & scl_p;

  wire pins_ok = ~cfg_pin_match | (shreg[3:1] == pin_addr);
  wire is_dac  = shreg[7:4] == DAC_TYPE;
  wire is_mem  = shreg[7:4] == (cfg_mem_alt ? MEM_TYPE_ALT : MEM_TYPE);
  wire allow   = is_dac ? (shreg[0] ? cfg_access[0] : cfg_access[1]) : (is_mem & ~cfg_mem_lock);
  wire addr_ok = pins_ok & (is_dac | is_mem) & allow & ~nv_busy;

  wire ack_open = fall & ~skip & (bitcnt == 4'd7);
  wire byte_end = fall & ~skip & (bitcnt == 4'd8);
  wire wr_byte  = ack_open & (st == S_WR);
  wire load_rd  = byte_end & ((st == S_DEV & sda_oe & rw) | (st == S_RD & mack));

  assign mem_we    = wr_byte & ~tgt_dac;
  assign mem_re    = load_rd & ~tgt_dac;
  assign mem_addr  = ptr;
  assign mem_wdata = shreg;
  assign nv_busy   = busy_cnt != '0;

  always_comb begin
    case (ptr)
      8'd0:    rd_dac = hib ? dac10[7:0] : {6'b0, dac10[9:8]};
      8'd2:    rd_dac = hib ? nv10[7:0]  : {6'b0, nv10[9:8]};
      8'd4:    rd_dac = dac8;
      8'd6:    rd_dac = nv8;
      default: rd_dac = 8'h00;
    endcase
    rd_byte = tgt_dac ? rd_dac : mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_r <= 3'b111; sda_r <= 3'b111; bitcnt <= '0;
      skip <= 1'b0; rw <= 1'b0; tgt_dac <= 1'b0; mack <= 1'b0; hib <= 1'b0;
      pend10 <= 1'b0; pend8 <= 1'b0; shreg <= '0; tx <= '0; ptr <= '0;
      hi_tmp <= '0; sda_oe <= 1'b0; busy_cnt <= '0;
      nv10 <= NV10_INIT; nv8 <= NV8_INIT;
      dac10 <= cfg_init10 ? NV10_INIT : '0;
      dac8  <= cfg_init8  ? NV8_INIT  : '0;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (start_ev) begin
        st <= S_DEV; bitcnt <= '0; skip <= 1'b1; hib <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        if (pend10) nv10 <= dac10;
        if (pend8)  nv8  <= dac8;
        if (pend10 | pend8) busy_cnt <= BW'(NV_BUSY_CYCLES);
        pend10 <= 1'b0; pend8 <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise && bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        if (rise && bitcnt == 4'd8) mack <= ~sda_s;
        if (fall) begin
          if (skip) skip <= 1'b0;
          else if (bitcnt < 4'd7) begin
            bitcnt <= bitcnt + 4'd1;
            if (st == S_RD) begin tx <= tx << 1; sda_oe <= ~tx[6]; end
          end else if (bitcnt == 4'd7) begin
            bitcnt <= 4'd8;
            case (st)
              S_DEV: begin
                rw <= shreg[0]; tgt_dac <= is_dac; sda_oe <= addr_ok;
                if (!addr_ok) st <= S_IDLE;
              end
              S_WORD: begin ptr <= shreg; sda_oe <= 1'b1; end
              S_WR: begin
                sda_oe <= 1'b1;
                if (!tgt_dac) ptr <= ptr + 8'd1;
                else if (ptr == 8'd0 || ptr == 8'd2) begin
                  if (!hib) begin hi_tmp <= shreg[1:0]; hib <= 1'b1; end
                  else begin
                    dac10 <= {hi_tmp, shreg}; hib <= 1'b0;
                    if (ptr == 8'd2) pend10 <= 1'b1;
                  end
                end else if (ptr == 8'd4 || ptr == 8'd6) begin
                  dac8 <= shreg;
                  if (ptr == 8'd6) pend8 <= 1'b1;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else begin
            bitcnt <= '0; sda_oe <= 1'b0;
            case (st)
              S_DEV:   st <= rw ? S_RD : S_WORD;
              S_WORD:  st <= S_WR;
              S_RD:    if (!mack) st <= S_IDLE;
              default: ;
            endcase
            if (load_rd) begin
              tx <= rd_byte; sda_oe <= ~rd_byte[7];
              if (!tgt_dac) ptr <= ptr + 8'd1;
              else begin
                if (ptr == 8'd0 || ptr == 8'd2) hib <= ~hib;
                if (ptr == 8'd2) dac10 <= nv10;
                if (ptr == 8'd6) dac8 <= nv8;
              end
            end
          end
        end
      end
    end
  end

  // R11: an address byte seen while busy is never acknowledged
  a_r11_busy_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && st == S_DEV && ack_open) |=> !sda_oe);
  // R7: the busy window opens only at a Stop
  a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> $past(stop_ev));
  // R3: SDA is released after a Stop
  a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
  // R9: no memory strobe while memory is locked
  a_r9_lock_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> !cfg_mem_lock);
  // R5: reading live words leaves both DAC outputs alone
  a_r5_live_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && tgt_dac && (ptr == 8'd0 || ptr == 8'd4)) |=> ($stable(dac10) && $stable(dac8)));
endmodule

// File: tb/i2c_dac_shadow_slave_tb.sv
`timescale 1ns/1ps
module i2c_dac_shadow_slave_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, mscl = 1'b1, msda = 1'b1;
  logic [2:0] pin_addr = 3'b101;
  logic [1:0] cfg_access = 2'b11;
  logic cfg_mem_lock = 1'b0, cfg_mem_alt = 1'b0, cfg_pin_match = 1'b1;
  logic cfg_init10 = 1'b1, cfg_init8 = 1'b0;
  logic sda_oe, mem_we, mem_re, nv_busy;
  logic [9:0] dac10;
  logic [7:0] dac8, mem_addr, mem_wdata, mem_rdata;
  logic [7:0] mem [256];

  wire sda_line = msda & ~sda_oe;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  i2c_dac_shadow_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(mscl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_addr(pin_addr), .cfg_access(cfg_access), .cfg_mem_lock(cfg_mem_lock),
    .cfg_mem_alt(cfg_mem_alt), .cfg_pin_match(cfg_pin_match),
    .cfg_init10(cfg_init10), .cfg_init8(cfg_init8), .dac10(dac10), .dac8(dac8),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .nv_busy(nv_busy));

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  logic a;
  logic [7:0] rb;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %0h expected none", act_q.pop_front());
      end else chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic wq();
    repeat (8) @(negedge clk);
  endtask

  task automatic i2c_start();
    msda = 1'b1; wq(); mscl = 1'b1; wq(); msda = 1'b0; wq(); mscl = 1'b0;
  endtask

  task automatic i2c_stop();
    msda = 1'b0; wq(); mscl = 1'b1; wq(); msda = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq(); mscl = 1'b1; wq(); mscl = 1'b0;
    end
    msda = 1'b1; wq(); mscl = 1'b1; wq(); ack = ~sda_line; mscl = 1'b0;
  endtask

  task automatic rbyte(input logic master_ack, input logic keep, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); mscl = 1'b1; wq(); b[i] = sda_line; mscl = 1'b0;
    end
    msda = ~master_ack; wq(); mscl = 1'b1; wq(); mscl = 1'b0; msda = 1'b1;
    if (keep) act_q.push_back(b);
  endtask

  task automatic addr_try(input logic [7:0] b, input logic exp_ack, input string tag);
    i2c_start(); wbyte(b, a); chk(tag, a, exp_ack);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk); rst_n = 1'b1; wq();
    chk("R12 dac10 init from shadow", dac10, 10'h155);
    chk("R12 dac8 init zero", dac8, 8'h00);
    chk("R12 busy idle", nv_busy, 1'b0);
    chk("R3 sda released idle", sda_oe, 1'b0);
    rst_n = 1'b0; cfg_init10 = 1'b0; cfg_init8 = 1'b1;
    repeat (3) @(negedge clk); rst_n = 1'b1; wq();
    chk("R12 dac10 init zero", dac10, 10'h000);
    chk("R12 dac8 init from shadow", dac8, 8'h80);

    // live 10-bit write
    addr_try(8'h9A, 1'b1, "R3 address ack");
    wbyte(8'h00, a); wbyte(8'h02, a);
    chk("R4 dac10 waits for low byte", dac10, 10'h000);
    wbyte(8'h34, a); chk("R3 data ack", a, 1'b1);
    chk("R4 dac10 written", dac10, 10'h234);
    i2c_stop();
    chk("R3 released after stop", sda_oe, 1'b0);

    // random read of live 10-bit
    addr_try(8'h9A, 1'b1, "R13 dummy write ack");
    wbyte(8'h00, a);
    addr_try(8'h9B, 1'b1, "R13 read ack");
    expect_byte(8'h02, "R13 live10 high byte"); rbyte(1'b1, 1'b1, rb);
    expect_byte(8'h34, "R5 live10 low byte");  rbyte(1'b0, 1'b1, rb);
    i2c_stop();
    chk("R5 dac10 unchanged by read", dac10, 10'h234);
    chk("R5 busy not started by read", nv_busy, 1'b0);

    // live 8-bit write
    addr_try(8'h9A, 1'b1, "R4 address"); wbyte(8'h04, a); wbyte(8'hA5, a); i2c_stop();
    chk("R4 dac8 written", dac8, 8'hA5);

    // shadow 8-bit write and busy
    addr_try(8'h9A, 1'b1, "R7 address"); wbyte(8'h06, a); wbyte(8'h3C, a);
    chk("R7 live loaded before stop", dac8, 8'h3C);
    chk("R7 no busy before stop", nv_busy, 1'b0);
    i2c_stop();
    chk("R7 busy after stop", nv_busy, 1'b1);
    addr_try(8'h9A, 1'b0, "R11 nack while busy"); i2c_stop();
    while (nv_busy) @(negedge clk);

    // overwrite live, then read shadow back
    addr_try(8'h9A, 1'b1, "R11 ack after busy"); wbyte(8'h04, a); wbyte(8'h11, a); i2c_stop();
    chk("R4 dac8 live overwrite", dac8, 8'h11);
    addr_try(8'h9A, 1'b1, "R6 dummy"); wbyte(8'h06, a);
    addr_try(8'h9B, 1'b1, "R6 read ack");
    expect_byte(8'h3C, "R6 shadow8 value"); rbyte(1'b0, 1'b1, rb); i2c_stop();
    chk("R6 dac8 copied from shadow", dac8, 8'h3C);

    addr_try(8'h9A, 1'b1, "R6 dummy10"); wbyte(8'h02, a);
    addr_try(8'h9B, 1'b1, "R6 read10 ack");
    expect_byte(8'h01, "R6 shadow10 high"); rbyte(1'b1, 1'b1, rb);
    expect_byte(8'h55, "R6 shadow10 low");  rbyte(1'b0, 1'b1, rb); i2c_stop();
    chk("R6 dac10 copied from shadow", dac10, 10'h155);

    // pin matching and type codes
    addr_try(8'h90, 1'b0, "R2 pin mismatch nack"); i2c_stop();
    cfg_pin_match = 1'b0;
    addr_try(8'h90, 1'b1, "R2 pins ignored ack"); i2c_stop();
    cfg_pin_match = 1'b1;
    addr_try(8'h5A, 1'b0, "R1 unknown type nack"); i2c_stop();

    // memory write with wrap, then reads
    addr_try(8'hAA, 1'b1, "R1 memory type ack"); wbyte(8'hFE, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); wbyte(8'h44, a);
    chk("R9 memory byte ack", a, 1'b1);
    i2c_stop();
    addr_try(8'hAA, 1'b1, "R10 dummy"); wbyte(8'hFE, a);
    addr_try(8'hAB, 1'b1, "R10 read ack");
    expect_byte(8'h11, "R10 mem FE"); rbyte(1'b1, 1'b1, rb);
    expect_byte(8'h22, "R10 mem FF"); rbyte(1'b1, 1'b1, rb);
    expect_byte(8'h33, "R10 mem 00 after wrap"); rbyte(1'b0, 1'b1, rb);
    i2c_stop();
    addr_try(8'hAB, 1'b1, "R10 current read ack");
    expect_byte(8'h44, "R10 current address continues"); rbyte(1'b0, 1'b1, rb);
    i2c_stop();

    cfg_mem_alt = 1'b1;
    addr_try(8'hAA, 1'b0, "R1 default code off when alt"); i2c_stop();
    addr_try(8'hEA, 1'b1, "R1 alternate code ack"); i2c_stop();
    cfg_mem_lock = 1'b1;
    addr_try(8'hEA, 1'b0, "R9 locked memory nack"); i2c_stop();
    cfg_mem_lock = 1'b0;

    // access rights
    cfg_access = 2'b01;
    addr_try(8'h9A, 1'b0, "R8 write refused");
    wbyte(8'h04, a); wbyte(8'h77, a); i2c_stop();
    chk("R8 refused write no effect", dac8, 8'h3C);
    addr_try(8'h9B, 1'b1, "R8 read allowed"); rbyte(1'b0, 1'b0, rb); i2c_stop();
    cfg_access = 2'b10;
    addr_try(8'h9B, 1'b0, "R8 read refused"); i2c_stop();
    addr_try(8'h9A, 1'b1, "R8 write allowed"); i2c_stop();
    cfg_access = 2'b00;
    addr_try(8'h9A, 1'b0, "R8 locked write"); i2c_stop();
    addr_try(8'h9B, 1'b0, "R8 locked read"); i2c_stop();

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d missing expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule